// File: doc/BRIEF.md
# GPIO Port with Flag Pin and Clock-Enable Steering

This block is an eight-bit general-purpose I/O port with a separate external flag output. Software sets the direction of each bit and the value of its output latch through a small register interface. The latch can be written whole, or individual bits can be set or cleared through write-one strobes. Each pin input passes through a two-flop synchronizer before it is read back.

The block also routes an SDRAM clock-enable signal from a memory controller onto one of two pins. A two-bit bus selection register chooses the pin. With the enable bit set, the select bit picks either GPIO bit 4 or the flag pin. That pin then gives up its normal function and carries the clock-enable. With the enable bit clear, both pins keep their normal functions.

The flag is a single output bit with its own commands: set, clear, and a status-register load that clears it. An active-low output-off input forces the flag pin's output enable off. After reset is released, the block captures the synchronized value of the four low GPIO pins once, as a boot-mode value.

Top module: `gpio_flag_mux`

## Requirements
- R1: `gpio_oe[i]` equals bit i of the direction register (address 0; 1 = output, 0 = input) for every bit not carrying the clock-enable.
- R2: A write to address 1 loads the output latch, and `gpio_out[i]` shows latch bit i for bits not carrying the clock-enable. A read of address 1 returns the latch bit for output bits and the synchronized pin for input bits.
- R3: A write to address 2 sets the latch bits written as 1 and leaves the others unchanged. A write to address 3 clears the latch bits written as 1 and leaves the others unchanged.
- R4: After reset, the direction register and the output latch are all zero, so all bits are inputs. The bus selection register is zero and `flag_out` is 1.
- R5: A read of an input bit reflects a pin change after exactly two rising clock edges, not after one.
- R6: After reset release, `boot_valid` rises within six cycles, with `boot_mode` equal to `gpio_in[3:0]`. Both then hold, whatever the pins do later.
- R7: The bus selection register is at address 4. Bit 0 is the clock-enable enable and bit 1 is the select. It reads back as written in bits [1:0], with zeros above.
- R8: With enable = 1 and select = 1, `gpio_oe[4]` is 1 and `gpio_out[4]` equals `cke_in`, whatever the direction and latch bit 4 hold. A read of address 1 bit 4 returns the synchronized pin. The flag pin works normally.
- R9: With enable = 1 and select = 0, `flag_out` equals `cke_in`, and GPIO bit 4 works as a normal GPIO bit.
- R10: With enable = 0, GPIO bit 4 and the flag work normally whatever the select bit holds.
- R11: `flag_set` drives the flag high on the next edge. `flag_clr` or `status_wr` drives it low. A clear wins when both arrive together.
- R12: While `out_off_n` is 0, `flag_oe` is 0. Otherwise `flag_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| flag_set | input | 1 | Flag set command |
| flag_clr | input | 1 | Flag clear command |
| status_wr | input | 1 | Status register load; clears the flag |
| cke_in | input | 1 | SDRAM clock-enable from the memory controller |
| out_off_n | input | 1 | Active-low output-off |
| gpio_in | input | 8 | Pin input values |
| gpio_out | output | 8 | Pin output values |
| gpio_oe | output | 8 | Pin output enables |
| flag_out | output | 1 | Flag pin output value |
| flag_oe | output | 1 | Flag pin output enable |
| boot_mode | output | 4 | Captured boot-mode value |
| boot_valid | output | 1 | Boot mode has been captured |

## Verification
The assertions check on every cycle the following:
- The result of set and clear strobes on the latch.
- The flag set/clear priority.
- The output-off override of the flag enable.
- The forced enable on GPIO bit 4 while it carries the clock-enable.
- That the boot mode stays frozen once valid.

Only the bench's scenarios show some other behaviours:
- The two-edge synchronizer latency.
- The mixed latch/pin readback.
- The reset values.
- That the select bit is ignored while the enable is clear.
- That pin changes after capture leave the boot mode alone.

// File: rtl/gpio_flag_pkg.sv
package gpio_flag_pkg;
  typedef enum logic [2:0] {
    ADDR_DIR    = 3'd0,
    ADDR_DATA   = 3'd1,
    ADDR_SET    = 3'd2,
    ADDR_CLR    = 3'd3,
    ADDR_BUSSEL = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic sel;
    logic en;
  } bussel_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] latch_q
);
  reg_addr_e    a;
  logic [W-1:0] dir_d, latch_d;
  logic         dir_ld, latch_ld;

  assign a = reg_addr_e'(addr);

  always_comb begin
    dir_d    = dir_q;
    latch_d  = latch_q;
    dir_ld   = 1'b0;
    latch_ld = 1'b0;
    if (wr_en) begin
      unique case (a)
        ADDR_DIR:  begin dir_d = wdata; dir_ld = 1'b1; end
        ADDR_DATA: begin latch_d = wdata; latch_ld = 1'b1; end
        ADDR_SET:  begin latch_d = latch_q | wdata; latch_ld = 1'b1; end
        ADDR_CLR:  begin latch_d = latch_q & ~wdata; latch_ld = 1'b1; end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      latch_q <= '0;
    end else begin
      if (dir_ld)   dir_q   <= dir_d;
      if (latch_ld) latch_q <= latch_d;
    end
  end

  assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2) |=> ((latch_q & $past(wdata)) == $past(wdata)));
  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3) |=> ((latch_q & $past(wdata)) == '0));
  assert_dir_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0) |=> (dir_q == $past(wdata)));
endmodule

// File: rtl/flag_unit.sv
module flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_cmd,
  input  logic clr_cmd,
  input  logic stat_wr,
  output logic flag_q
);
  logic flag_d, clr_any;

  assign clr_any = clr_cmd | stat_wr;

  always_comb begin
    flag_d = flag_q;
    if (clr_any)      flag_d = 1'b0;
    else if (set_cmd) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b1;
    else        flag_q <= flag_d;
  end

  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd || stat_wr) |=> !flag_q);
  assert_set_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cmd && !clr_cmd && !stat_wr) |=> flag_q);
endmodule

// File: rtl/gpio_flag_mux.sv
module gpio_flag_mux
  import gpio_flag_pkg::*;
#(
  parameter int N_GPIO  = 8,
  parameter int BOOT_W  = 4,
  parameter int CKE_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [N_GPIO-1:0] reg_wdata,
  output logic [N_GPIO-1:0] reg_rdata,
  input  logic              flag_set,
  input  logic              flag_clr,
  input  logic              status_wr,
  input  logic              cke_in,
  input  logic              out_off_n,
  input  logic [N_GPIO-1:0] gpio_in,
  output logic [N_GPIO-1:0] gpio_out,
  output logic [N_GPIO-1:0] gpio_oe,
  output logic              flag_out,
  output logic              flag_oe,
  output logic [BOOT_W-1:0] boot_mode,
  output logic              boot_valid
);
  localparam int BOOT_WAIT = 2;
  localparam int CNT_W     = $clog2(BOOT_WAIT + 1);

  logic              rst_meta_q, rst_i;
  logic [N_GPIO-1:0] pin_s, dir_q, latch_q, rd_data_bits;
  logic              flag_q, cke_on_gpio, cke_on_flag;
  bussel_t           bus_q, bus_d;
  logic              bus_ld;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en, cap_en;
  reg_addr_e         a;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_i      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_i      <= rst_meta_q;
    end
  end

  gpio_sync #(.W(N_GPIO)) u_sync (.clk(clk), .rst_n(rst_i), .d(gpio_in), .q(pin_s));

  gpio_bank #(.W(N_GPIO)) u_bank (
    .clk(clk), .rst_n(rst_i), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .dir_q(dir_q), .latch_q(latch_q));

  flag_unit u_flag (
    .clk(clk), .rst_n(rst_i), .set_cmd(flag_set), .clr_cmd(flag_clr),
    .stat_wr(status_wr), .flag_q(flag_q));

  // bus selection register
  assign a = reg_addr_e'(reg_addr);
  always_comb begin
    bus_ld = reg_wr && (a == ADDR_BUSSEL);
    bus_d  = '{sel: reg_wdata[1], en: reg_wdata[0]};
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      bus_q <= '0;
    else if (bus_ld) bus_q <= bus_d;
  end

  assign cke_on_gpio = bus_q.en &  bus_q.sel;
  assign cke_on_flag = bus_q.en & ~bus_q.sel;

  // per-pin output steering and readback
  for (genvar i = 0; i < N_GPIO; i++) begin : g_pin
    if (i == CKE_BIT) begin : g_cke
      assign gpio_out[i]     = cke_on_gpio ? cke_in : latch_q[i];
      assign gpio_oe[i]      = cke_on_gpio | dir_q[i];
      assign rd_data_bits[i] = (dir_q[i] && !cke_on_gpio) ? latch_q[i] : pin_s[i];
    end else begin : g_std
      assign gpio_out[i]     = latch_q[i];
      assign gpio_oe[i]      = dir_q[i];
      assign rd_data_bits[i] = dir_q[i] ? latch_q[i] : pin_s[i];
    end
  end

  assign flag_out = cke_on_flag ? cke_in : flag_q;
  assign flag_oe  = out_off_n;

  always_comb begin
    reg_rdata = '0;
    unique case (a)
      ADDR_DIR:    reg_rdata = dir_q;
      ADDR_DATA:   reg_rdata = rd_data_bits;
      ADDR_BUSSEL: reg_rdata[1:0] = {bus_q.sel, bus_q.en};
      default:     reg_rdata = '0;
    endcase
  end

  // one-time boot-mode capture
  always_comb begin
    cnt_en = !boot_valid && (cnt_q != CNT_W'(BOOT_WAIT));
    cap_en = !boot_valid && (cnt_q == CNT_W'(BOOT_WAIT));
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cnt_q      <= '0;
      boot_mode  <= '0;
      boot_valid <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (cap_en) begin
        boot_mode  <= pin_s[BOOT_W-1:0];
        boot_valid <= 1'b1;
      end
    end
  end

  assert_flag_off_R12: assert property (@(posedge clk) disable iff (!rst_i)
    !out_off_n |-> !flag_oe);
  assert_cke_gpio_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_q.en && bus_q.sel) |-> (gpio_oe[CKE_BIT] && gpio_out[CKE_BIT] == cke_in));
  assert_cke_flag_R9: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_q.en && !bus_q.sel) |-> (flag_out == cke_in));
  assert_boot_hold_R6: assert property (@(posedge clk) disable iff (!rst_i)
    boot_valid |=> (boot_valid && $stable(boot_mode)));
endmodule

// File: tb/sim_gpio_flag_mux.sv
`timescale 1ns/1ps
module sim_gpio_flag_mux;
  logic       clk = 1'b0;
  logic       rst_n, reg_wr, flag_set, flag_clr, status_wr, cke_in, out_off_n;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, gpio_in, gpio_out, gpio_oe;
  logic       flag_out, flag_oe, boot_valid;
  logic [3:0] boot_mode;
  int         n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  gpio_flag_mux u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flag_set(flag_set),
    .flag_clr(flag_clr), .status_wr(status_wr), .cke_in(cke_in),
    .out_off_n(out_off_n), .gpio_in(gpio_in), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe), .flag_out(flag_out), .flag_oe(flag_oe),
    .boot_mode(boot_mode), .boot_valid(boot_valid));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] ad, logic [7:0] d);
    reg_addr = ad; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] ad, output logic [7:0] d);
    reg_addr = ad; #0.5; d = reg_rdata;
  endtask

  task automatic t_reset_boot();
    logic [7:0] d;
    rst_n = 1'b0; gpio_in = 8'h0A; tick(2);
    rst_n = 1'b1; tick();
    chk("R6 valid low just after release", boot_valid, 1'b0);
    tick(6);
    chk("R6 valid", boot_valid, 1'b1);
    chk("R6 mode", boot_mode, 4'hA);
    chk("R4 oe", gpio_oe, 8'h00);
    chk("R4 out", gpio_out, 8'h00);
    chk("R4 flag", flag_out, 1'b1);
    rd(3'd4, d); chk("R4 bussel", d, 8'h00);
    rd(3'd0, d); chk("R4 dir", d, 8'h00);
    gpio_in = 8'h05; tick(4);
    chk("R6 hold mode", boot_mode, 4'hA);
  endtask

  task automatic t_dir_data();
    logic [7:0] d;
    wr(3'd0, 8'hF0); chk("R1 oe", gpio_oe, 8'hF0);
    wr(3'd1, 8'hA5); chk("R2 out", gpio_out, 8'hA5);
    gpio_in = 8'h3C; tick(2);
    rd(3'd1, d); chk("R2 mixed read", d, 8'hAC);
  endtask

  task automatic t_set_clr();
    wr(3'd2, 8'h42); chk("R3 set", gpio_out, 8'hE7);
    wr(3'd3, 8'h81); chk("R3 clr", gpio_out, 8'h66);
  endtask

  task automatic t_sync();
    logic [7:0] d;
    wr(3'd0, 8'h00);
    gpio_in = 8'h00; tick(3);
    gpio_in = 8'h01; tick();
    rd(3'd1, d); chk("R5 one edge old", d[0], 1'b0);
    tick();
    rd(3'd1, d); chk("R5 two edges new", d[0], 1'b1);
  endtask

  task automatic t_cke();
    logic [7:0] d;
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); gpio_in = 8'h10; tick(2);
    wr(3'd4, 8'h03);
    rd(3'd4, d); chk("R7 readback", d, 8'h03);
    cke_in = 1'b1; #0.5;
    chk("R8 oe4", gpio_oe[4], 1'b1);
    chk("R8 out4", gpio_out[4], 1'b1);
    chk("R8 flag normal", flag_out, 1'b1);
    cke_in = 1'b0; #0.5; chk("R8 out4 follows", gpio_out[4], 1'b0);
    wr(3'd0, 8'h10); rd(3'd1, d); chk("R8 read pin", d[4], 1'b1);
    wr(3'd4, 8'h01); cke_in = 1'b0; #0.5;
    chk("R9 flag cke", flag_out, 1'b0);
    chk("R9 gpio4 normal", gpio_out[4], 1'b0);
    cke_in = 1'b1; #0.5; chk("R9 flag follows", flag_out, 1'b1);
    wr(3'd4, 8'h02); cke_in = 1'b0; #0.5;
    chk("R10 flag", flag_out, 1'b1);
    chk("R10 gpio4 out", gpio_out[4], 1'b0);
    chk("R10 gpio4 oe", gpio_oe[4], 1'b1);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_flag();
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    chk("R11 clr", flag_out, 1'b0);
    flag_set = 1'b1; tick(); flag_set = 1'b0;
    chk("R11 set", flag_out, 1'b1);
    status_wr = 1'b1; tick(); status_wr = 1'b0;
    chk("R11 status", flag_out, 1'b0);
    flag_set = 1'b1; tick();
    flag_clr = 1'b1; tick(); flag_set = 1'b0; flag_clr = 1'b0;
    chk("R11 clear wins", flag_out, 1'b0);
    out_off_n = 1'b0; #0.5; chk("R12 off", flag_oe, 1'b0);
    out_off_n = 1'b1; #0.5; chk("R12 on", flag_oe, 1'b1);
  endtask

  initial begin
    reg_wr = 0; reg_addr = 0; reg_wdata = 0; flag_set = 0; flag_clr = 0;
    status_wr = 0; cke_in = 0; out_off_n = 1; gpio_in = 0; rst_n = 0;
    t_reset_boot();
    t_dir_data();
    t_set_clr();
    t_sync();
    t_cke();
    t_flag();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule